// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Controller with Atomic Bit Set/Clear

This block controls one port of sixteen general-purpose pins from a simple 32-bit register bus that has a write strobe, a byte address, write data and combinational read data. Software sets each pin's direction, drive style, speed class and pull resistor, reads the pin levels, and writes the output levels.

Output levels can be changed in two ways. A plain write to the output register replaces all sixteen bits. A write to the set/clear register changes only the bits it marks: the low half raises bits and the high half lowers them. If both halves mark the same bit, the raise wins. Because the whole change happens in one bus write, no read-modify-write sequence is needed and no lock is held.

Pin inputs pass through a two-stage synchronizer and then a capture register. The pin control outputs are decoded from the configuration registers. Alternate-function and analog pins are flagged, and the logic outside the block owns those pins.

Top module: `gpio_port16`

## Requirements
- R1: An active-low reset clears every configuration register and the output register. After reset every register reads 0 and pin_out, pin_oe, pin_od, pin_pu, pin_pd, pin_alt, pin_ana and pin_speed are all 0.
- R2: The registers sit at fixed byte offsets and read back what was written. Offset 0x00 is mode (2 bits per pin, pin i at bits 2i+1:2i). Offset 0x04 is output type (bit i = pin i, bits 31:16 read 0). Offset 0x08 is speed (2 bits per pin). Offset 0x0C is pull (2 bits per pin).
- R3: Offset 0x10 returns the pin input levels in bits 15:0. Writes to this offset have no effect. A change on pin_in shows in this register on the third rising edge after it, and not on the second.
- R4: A write to offset 0x14 replaces output bits 15:0 with wdata[15:0], and pin_out follows on the next edge. Bits 31:16 of this register read 0.
- R5: A write to offset 0x18 sets output bit i when wdata[i] is 1 and clears it when wdata[16+i] is 1. Bits whose two controls are both 0 keep their value.
- R6: If one set/clear write has both wdata[i] and wdata[16+i] at 1, output bit i becomes 1.
- R7: Offset 0x18 always reads 0. After a set/clear write, a later direct write to 0x14 still sets every output bit.
- R8: Mode code 01 drives pin_oe[i]. Code 10 drives pin_alt[i]. Code 11 drives pin_ana[i]. Code 00 drives none of the three.
- R9: pin_od[i] equals output-type bit i (1 = open-drain). pin_speed carries the speed register unchanged.
- R10: Pull code 01 drives pin_pu[i] and code 10 drives pin_pd[i]. Codes 00 and 11 drive neither. The pull applies whatever the mode is.
- R11: A write to an unmapped offset (0x1C, or any address with bits 1:0 not zero) changes nothing. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Pin levels as seen at the pads |
| pin_out | output | 16 | Output level per pin |
| pin_oe | output | 16 | Output enable per pin |
| pin_od | output | 16 | Open-drain select per pin |
| pin_pu | output | 16 | Pull-up request per pin |
| pin_pd | output | 16 | Pull-down request per pin |
| pin_alt | output | 16 | Pin given to alternate-function logic |
| pin_ana | output | 16 | Pin given to analog logic |
| pin_speed | output | 32 | Speed class, 2 bits per pin |

## Verification
The bound checker watches the output register on every cycle. After each set/clear write it confirms that marked bits rose, that bits marked only for clearing fell, and that unmarked bits kept their value. After each direct write it confirms the new value, and with no write it confirms that nothing moved. On every cycle it also checks that the enable, alternate and analog flags never overlap, that the pull-up and pull-down requests are never both active, that the set/clear offset reads 0, and that the input register lags pin_in by exactly three edges. Some behaviours need a scenario to show them: the reset values, readback at each offset, writes to the read-only and unmapped offsets being ignored, and the decode of every mode and pull code. The bench's scenarios cover these.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'b00,
        PM_OUTPUT = 2'b01,
        PM_ALTFN  = 2'b10,
        PM_ANALOG = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        PL_NONE = 2'b00,
        PL_UP   = 2'b01,
        PL_DOWN = 2'b10,
        PL_RSVD = 2'b11
    } pull_sel_e;

    // Word index (byte offset / 4) of each register
    localparam int RI_MODE   = 0;
    localparam int RI_OTYPE  = 1;
    localparam int RI_SPEED  = 2;
    localparam int RI_PULL   = 3;
    localparam int RI_IN     = 4;
    localparam int RI_OUT    = 5;
    localparam int RI_SETCLR = 6;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] in_val
);

    typedef struct packed {
        logic [NPINS-1:0] stage1;
        logic [NPINS-1:0] stage2;
        logic [NPINS-1:0] capture;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.stage1  = pin_in;
        s_d.stage2  = s_q.stage1;
        s_d.capture = s_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_val = s_q.capture;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int DW    = 32,
    parameter int AW    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NPINS-1:0]   in_val,
    output logic [2*NPINS-1:0] cfg_mode,
    output logic [NPINS-1:0]   cfg_otype,
    output logic [2*NPINS-1:0] cfg_speed,
    output logic [2*NPINS-1:0] cfg_pull,
    output logic [NPINS-1:0]   out_val
);

    localparam int FW = 2 * NPINS;
    localparam int IW = AW - 2;

    typedef struct packed {
        logic [FW-1:0]    mode;
        logic [NPINS-1:0] otype;
        logic [FW-1:0]    speed;
        logic [FW-1:0]    pull;
        logic [NPINS-1:0] odata;
    } regs_t;

    regs_t            r_d, r_q;
    logic             aligned;
    logic [IW-1:0]    widx;
    logic [NPINS-1:0] set_mask;
    logic [NPINS-1:0] clr_mask;

    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        widx     = bus_addr[AW-1:2];
        set_mask = bus_wdata[NPINS-1:0];
        clr_mask = bus_wdata[FW-1:NPINS];
        r_d      = r_q;
        if (bus_we && aligned) begin
            if (widx == IW'(RI_MODE)) begin
                r_d.mode = bus_wdata[FW-1:0];
            end else if (widx == IW'(RI_OTYPE)) begin
                r_d.otype = bus_wdata[NPINS-1:0];
            end else if (widx == IW'(RI_SPEED)) begin
                r_d.speed = bus_wdata[FW-1:0];
            end else if (widx == IW'(RI_PULL)) begin
                r_d.pull = bus_wdata[FW-1:0];
            end else if (widx == IW'(RI_OUT)) begin
                r_d.odata = bus_wdata[NPINS-1:0];
            end else if (widx == IW'(RI_SETCLR)) begin
                // raise wins: clear first, then OR the set mask
                r_d.odata = (r_q.odata & ~clr_mask) | set_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (widx == IW'(RI_MODE)) begin
                bus_rdata[FW-1:0] = r_q.mode;
            end else if (widx == IW'(RI_OTYPE)) begin
                bus_rdata[NPINS-1:0] = r_q.otype;
            end else if (widx == IW'(RI_SPEED)) begin
                bus_rdata[FW-1:0] = r_q.speed;
            end else if (widx == IW'(RI_PULL)) begin
                bus_rdata[FW-1:0] = r_q.pull;
            end else if (widx == IW'(RI_IN)) begin
                bus_rdata[NPINS-1:0] = in_val;
            end else if (widx == IW'(RI_OUT)) begin
                bus_rdata[NPINS-1:0] = r_q.odata;
            end
        end
    end

    assign cfg_mode  = r_q.mode;
    assign cfg_otype = r_q.otype;
    assign cfg_speed = r_q.speed;
    assign cfg_pull  = r_q.pull;
    assign out_val   = r_q.odata;

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic [2*NPINS-1:0] cfg_mode,
    input  logic [NPINS-1:0]   cfg_otype,
    input  logic [2*NPINS-1:0] cfg_speed,
    input  logic [2*NPINS-1:0] cfg_pull,
    output logic [NPINS-1:0]   pin_oe,
    output logic [NPINS-1:0]   pin_od,
    output logic [NPINS-1:0]   pin_pu,
    output logic [NPINS-1:0]   pin_pd,
    output logic [NPINS-1:0]   pin_alt,
    output logic [NPINS-1:0]   pin_ana,
    output logic [2*NPINS-1:0] pin_speed
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_mode_e mode_i;
        pull_sel_e pull_i;

        always_comb begin
            mode_i     = pin_mode_e'(cfg_mode[2*i +: 2]);
            pull_i     = pull_sel_e'(cfg_pull[2*i +: 2]);
            pin_oe[i]  = (mode_i == PM_OUTPUT);
            pin_alt[i] = (mode_i == PM_ALTFN);
            pin_ana[i] = (mode_i == PM_ANALOG);
            pin_pu[i]  = (pull_i == PL_UP);
            pin_pd[i]  = (pull_i == PL_DOWN);
        end
    end

    assign pin_od    = cfg_otype;
    assign pin_speed = cfg_speed;

endmodule

// File: rtl/gpio_port16.sv
module gpio_port16 #(
    parameter int NPINS = 16,
    parameter int DW    = 32,
    parameter int AW    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe,
    output logic [NPINS-1:0]   pin_od,
    output logic [NPINS-1:0]   pin_pu,
    output logic [NPINS-1:0]   pin_pd,
    output logic [NPINS-1:0]   pin_alt,
    output logic [NPINS-1:0]   pin_ana,
    output logic [2*NPINS-1:0] pin_speed
);

    localparam int FW = 2 * NPINS;

    logic [NPINS-1:0] in_val;
    logic [FW-1:0]    cfg_mode;
    logic [NPINS-1:0] cfg_otype;
    logic [FW-1:0]    cfg_speed;
    logic [FW-1:0]    cfg_pull;

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .in_val (in_val)
    );

    gpio_regfile #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_val    (in_val),
        .cfg_mode  (cfg_mode),
        .cfg_otype (cfg_otype),
        .cfg_speed (cfg_speed),
        .cfg_pull  (cfg_pull),
        .out_val   (pin_out)
    );

    gpio_pin_ctrl #(.NPINS(NPINS)) u_ctrl (
        .cfg_mode  (cfg_mode),
        .cfg_otype (cfg_otype),
        .cfg_speed (cfg_speed),
        .cfg_pull  (cfg_pull),
        .pin_oe    (pin_oe),
        .pin_od    (pin_od),
        .pin_pu    (pin_pu),
        .pin_pd    (pin_pd),
        .pin_alt   (pin_alt),
        .pin_ana   (pin_ana),
        .pin_speed (pin_speed)
    );

endmodule

// File: rtl/gpio_port16_chk.sv
module gpio_port16_chk #(
    parameter int NPINS = 16,
    parameter int DW    = 32,
    parameter int AW    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [AW-1:0]      bus_addr,
    input logic [DW-1:0]      bus_wdata,
    input logic [DW-1:0]      bus_rdata,
    input logic [NPINS-1:0]   pin_in,
    input logic [NPINS-1:0]   in_val,
    input logic [NPINS-1:0]   pin_out,
    input logic [NPINS-1:0]   pin_oe,
    input logic [NPINS-1:0]   pin_od,
    input logic [NPINS-1:0]   pin_pu,
    input logic [NPINS-1:0]   pin_pd,
    input logic [NPINS-1:0]   pin_alt,
    input logic [NPINS-1:0]   pin_ana,
    input logic [2*NPINS-1:0] pin_speed
);

    localparam int FW = 2 * NPINS;

    logic             sc_addr;
    logic             out_addr;
    logic [NPINS-1:0] w_set;
    logic [NPINS-1:0] w_clr;
    logic [2:0]       run_cnt;

    assign sc_addr  = (bus_addr == AW'(24));
    assign out_addr = (bus_addr == AW'(20));
    assign w_set    = bus_wdata[NPINS-1:0];
    assign w_clr    = bus_wdata[FW-1:NPINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (run_cnt != 3'd4) begin
            run_cnt <= run_cnt + 3'd1;
        end
    end

    // R5
    sc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sc_addr) |=> ((pin_out & $past(w_set)) == $past(w_set)));

    // R6
    sc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sc_addr) |=> ((pin_out & $past(w_clr) & ~$past(w_set)) == '0));

    // R5
    sc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sc_addr) |=>
        (((pin_out ^ $past(pin_out)) & ~($past(w_set) | $past(w_clr))) == '0));

    // R4
    direct_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && out_addr) |=> (pin_out == $past(bus_wdata[NPINS-1:0])));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pu)
                     && $stable(pin_od) && $stable(pin_speed)));

    // R7
    sc_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_addr |-> (bus_rdata == '0));

    // R8
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & pin_alt) | (pin_oe & pin_ana) | (pin_alt & pin_ana)) == '0);

    // R10
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_pd) == '0);

    // R3
    in_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 3'd4) |-> (in_val == $past(pin_in, 3)));

endmodule

bind gpio_port16 gpio_port16_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .in_val    (in_val),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_od    (pin_od),
    .pin_pu    (pin_pu),
    .pin_pd    (pin_pd),
    .pin_alt   (pin_alt),
    .pin_ana   (pin_ana),
    .pin_speed (pin_speed)
);

// File: tb/sim_gpio_port16.sv
`timescale 1ns/1ps
module sim_gpio_port16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pin_od, pin_pu, pin_pd, pin_alt, pin_ana;
    logic [31:0] pin_speed;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port16 u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od), .pin_pu(pin_pu),
        .pin_pd(pin_pd), .pin_alt(pin_alt), .pin_ana(pin_ana),
        .pin_speed(pin_speed)
    );

    typedef struct packed {
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  raddr;
        logic [31:0] expv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{5'h00, 32'h0000_5555, 5'h00, 32'h0000_5555, 8'd2},  // R2 mode readback
        '{5'h14, 32'h1234_A5A5, 5'h14, 32'h0000_A5A5, 8'd4},  // R4 direct write
        '{5'h18, 32'h0000_000F, 5'h14, 32'h0000_A5AF, 8'd5},  // R5 set low bits
        '{5'h18, 32'h00F0_0000, 5'h14, 32'h0000_A50F, 8'd5},  // R5 clear bits 7:4
        '{5'h18, 32'h0030_0030, 5'h14, 32'h0000_A53F, 8'd6},  // R6 set wins
        '{5'h18, 32'h0000_0000, 5'h14, 32'h0000_A53F, 8'd5},  // R5 zero write
        '{5'h18, 32'hFFFF_0000, 5'h18, 32'h0000_0000, 8'd7},  // R7 reads zero
        '{5'h18, 32'h0000_0000, 5'h14, 32'h0000_0000, 8'd5},  // R5 all cleared
        '{5'h14, 32'h0000_FFFF, 5'h14, 32'h0000_FFFF, 8'd7},  // R7 no lock
        '{5'h04, 32'hFFFF_00FF, 5'h04, 32'h0000_00FF, 8'd2},  // R2 otype
        '{5'h08, 32'hDEAD_BEEF, 5'h08, 32'hDEAD_BEEF, 8'd2},  // R2 speed
        '{5'h0C, 32'h0000_E4E4, 5'h0C, 32'h0000_E4E4, 8'd2},  // R2 pull
        '{5'h1C, 32'hFFFF_FFFF, 5'h1C, 32'h0000_0000, 8'd11}, // R11 unmapped read
        '{5'h10, 32'h0000_FFFF, 5'h10, 32'h0000_0000, 8'd3},  // R3 read-only
        '{5'h15, 32'h0000_0000, 5'h14, 32'h0000_FFFF, 8'd11}  // R11 misaligned write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_reset_state(input string tag);
        logic [31:0] rd;
        for (int k = 0; k < 8; k++) begin
            bus_read(5'(k * 4), rd);
            check({tag, " reg"}, rd, 32'h0);
        end
        check({tag, " pin_out"}, {16'h0, pin_out}, 32'h0);
        check({tag, " pin_oe"}, {16'h0, pin_oe}, 32'h0);
        check({tag, " pulls"}, {pin_pu, pin_pd}, 32'h0);
        check({tag, " alt/ana/od"}, {pin_alt | pin_ana, pin_od}, 32'h0);
        check({tag, " speed"}, pin_speed, 32'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL all-R watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1 initial");

        for (int v = 0; v < NV; v++) begin
            bus_write(VECS[v].waddr, VECS[v].wdata);
            bus_read(VECS[v].raddr, rd);
            check($sformatf("R%0d vector %0d", VECS[v].req, v), rd, VECS[v].expv);
        end

        // R8 R10 R9: pins cycle through codes 00,01,10,11
        bus_write(5'h00, 32'hE4E4_E4E4);
        bus_write(5'h0C, 32'hE4E4_E4E4);
        check("R8 pin_oe", {16'h0, pin_oe}, 32'h0000_2222);
        check("R8 pin_alt", {16'h0, pin_alt}, 32'h0000_4444);
        check("R8 pin_ana", {16'h0, pin_ana}, 32'h0000_8888);
        check("R10 pin_pu", {16'h0, pin_pu}, 32'h0000_2222);
        check("R10 pin_pd", {16'h0, pin_pd}, 32'h0000_4444);
        check("R9 pin_od", {16'h0, pin_od}, 32'h0000_00FF);
        check("R9 pin_speed", pin_speed, 32'hDEAD_BEEF);
        check("R4 pin_out", {16'h0, pin_out}, 32'h0000_FFFF);

        // R3 input latency: visible on third edge, not second
        @(negedge clk);
        pin_in = 16'hBEEF;
        repeat (2) @(negedge clk);
        bus_read(5'h10, rd);
        check("R3 after two edges", rd, 32'h0);
        @(negedge clk);
        bus_read(5'h10, rd);
        check("R3 after three edges", rd, 32'h0000_BEEF);

        // R6 per-bit set wins across the whole port
        bus_write(5'h14, 32'h0000_0000);
        bus_write(5'h18, 32'hFFFF_FFFF);
        check("R6 all set+clear", {16'h0, pin_out}, 32'h0000_FFFF);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        pin_in = 16'h0;
        repeat (4) @(negedge clk);
        check_reset_state("R1 mid-run");
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule